// File: doc/BRIEF.md
# Watchdog Timer with Keyed Configuration Lock

This block is a watchdog timer on a small 16-bit register bus (address, write enable, write data, combinational read data). A counter runs while the watchdog is enabled. If software lets it reach the programmed timeout, the block raises a one-cycle reset request. Software restarts the count by writing a two-word refresh sequence. The control and timeout registers are write-protected. To change them, software first writes two fixed keys to a key register, in order and close together in time. This opens a configuration window of a fixed number of cycles. Inside that window software may reprogram the timeout or switch the watchdog off.

A wrong key, or a second key that arrives too late, is treated as a runaway program and also raises a reset request. Two status outputs, `unlocked` and `win_left`, expose the lock state and the cycles left in the window. Generating the actual system reset is the job of the logic that consumes `rst_req`.

Top module: `wdog_guard`

## Requirements
- R1: After reset, control reads 0x0001 (watchdog enabled), timeout reads 1000 (0x03E8), the block is locked with `win_left` = 0, and `rst_req` is low.
- R2: Writing 0xC520 and then 0xD928 to byte offset 0xE unlocks the block. In the cycle after the second key, `unlocked` is 1 and `win_left` is 256.
- R3: The second key is accepted on any of the 1st through 20th clock edges after the first key. If no key write arrives by the 20th edge, `rst_req` pulses after that edge and the block stays locked.
- R4: A first key other than 0xC520, or a second key other than 0xD928, makes `rst_req` high in the cycle after the write and leaves the block locked.
- R5: While unlocked, `win_left` falls by one per cycle. Writes to control (offset 0x0) and timeout (offset 0x2) are accepted on the 256 edges after the second key. After that the block relocks with `win_left` = 0.
- R6: Writes to control or timeout while locked are ignored, and the registers keep their values.
- R7: Reads are combinational. Offset 0x0 returns control, 0x2 returns timeout, 0x6 returns the live count, 0xE returns the lock state in bit 0, and any other offset returns 0. Control reads back exactly what was written, so read-modify-write works.
- R8: While control bit 0 is 1, the count rises by one per cycle from 0. When it reaches the timeout value, `rst_req` is high for the next cycle only and the count restarts at 0, so with timeout T the period is T+1 cycles.
- R9: Writing 0x5A5A and then 0xA5A5 to offset 0x4 clears the count. If any other value follows 0x5A5A, the sequence is dropped without clearing. A lone 0xA5A5 does nothing, and unlocking does not touch the count.
- R10: Clearing control bit 0 inside the window holds the count at 0, and no timeout request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| rst_req | output | 1 | One-cycle reset request pulse |
| unlocked | output | 1 | Configuration window is open |
| win_left | output | 9 | Cycles remaining in the configuration window |

## Verification
Every register and status result is updated by the clock edge that takes the write, so the bench drives on the falling edge and samples at the next falling edge. Reads are combinational and are sampled one time unit after the address is set.

A reset request is registered, so it is checked one cycle after the offending write, after the 20th gap edge, or after the edge on which the count equals the timeout. The window and gap limits are counted exactly by idling a known number of edges: 19 or 255 idle cycles land on the last accepted edge, and one more idle cycle lands just past it. Count read-backs are compared against the number of edges since the last refresh.

// File: rtl/wdog_guard_pkg.sv
package wdog_guard_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 16'hC520;
    localparam logic [DATA_W-1:0] KEY_SECOND = 16'hD928;
    localparam logic [DATA_W-1:0] REF_FIRST  = 16'h5A5A;
    localparam logic [DATA_W-1:0] REF_SECOND = 16'hA5A5;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_TMO  = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_REF  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h6;
    localparam logic [ADDR_W-1:0] OFS_KEY  = 4'hE;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_HALF,
        LK_OPEN
    } lock_state_e;
endpackage

// File: rtl/wdog_unlock_seq.sv
module wdog_unlock_seq
    import wdog_guard_pkg::*;
#(
    parameter int GAP_LIMIT  = 20,
    parameter int WIN_CYCLES = 256,
    localparam int GAP_W = $clog2(GAP_LIMIT + 1),
    localparam int WIN_W = $clog2(WIN_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              open,
    output logic [WIN_W-1:0]  win_left,
    output logic              fault
);
    typedef struct packed {
        lock_state_e      st;
        logic [GAP_W-1:0] gap;
        logic [WIN_W-1:0] win;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        fault = 1'b0;
        case (r_q.st)
            LK_IDLE: begin
                if (key_wr) begin
                    if (key_data == KEY_FIRST) begin
                        r_d.st  = LK_HALF;
                        r_d.gap = GAP_W'(1);
                    end else begin
                        fault = 1'b1;
                    end
                end
            end
            LK_HALF: begin
                if (key_wr) begin
                    r_d.gap = '0;
                    if (key_data == KEY_SECOND) begin
                        r_d.st  = LK_OPEN;
                        r_d.win = WIN_W'(WIN_CYCLES);
                    end else begin
                        r_d.st = LK_IDLE;
                        fault  = 1'b1;
                    end
                end else if (r_q.gap == GAP_W'(GAP_LIMIT)) begin
                    r_d.st  = LK_IDLE;
                    r_d.gap = '0;
                    fault   = 1'b1;
                end else begin
                    r_d.gap = r_q.gap + 1'b1;
                end
            end
            LK_OPEN: begin
                if (r_q.win == WIN_W'(1)) begin
                    r_d.st  = LK_IDLE;
                    r_d.win = '0;
                end else begin
                    r_d.win = r_q.win - 1'b1;
                end
            end
            default: r_d = '{st: LK_IDLE, gap: '0, win: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: LK_IDLE, gap: '0, win: '0};
        else        r_q <= r_d;
    end

    assign open     = (r_q.st == LK_OPEN);
    assign win_left = r_q.win;
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] tmo,
    input  logic              ref_wr,
    input  logic [DATA_W-1:0] ref_data,
    output logic [DATA_W-1:0] cnt,
    output logic              expire
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              armed;
    } cnt_t;

    cnt_t r_d, r_q;
    logic clear;

    always_comb begin
        r_d    = r_q;
        clear  = 1'b0;
        expire = en && (r_q.cnt >= tmo);
        if (ref_wr) begin
            clear       = r_q.armed && (ref_data == REF_SECOND);
            r_d.armed   = !r_q.armed && (ref_data == REF_FIRST);
        end
        if (!en || expire || clear) r_d.cnt = '0;
        else                        r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cnt: '0, armed: 1'b0};
        else        r_q <= r_d;
    end

    assign cnt = r_q.cnt;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_guard_pkg::*;
#(
    parameter int                GAP_LIMIT  = 20,
    parameter int                WIN_CYCLES = 256,
    parameter logic [DATA_W-1:0] TMO_RESET  = 16'd1000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic                              bus_we,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    output logic                              rst_req,
    output logic                              unlocked,
    output logic [$clog2(WIN_CYCLES+1)-1:0]   win_left
);
    localparam int WIN_W = $clog2(WIN_CYCLES + 1);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] tmo;
        logic              req;
    } top_t;

    top_t r_d, r_q;
    logic              fault, expire, open;
    logic [WIN_W-1:0]  win;
    logic [DATA_W-1:0] cnt_val;
    logic [DATA_W-1:0] ctrl_q, tmo_q;

    wdog_unlock_seq #(
        .GAP_LIMIT (GAP_LIMIT),
        .WIN_CYCLES(WIN_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (bus_we && (bus_addr == OFS_KEY)),
        .key_data(bus_wdata),
        .open    (open),
        .win_left(win),
        .fault   (fault)
    );

    wdog_count u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (r_q.ctrl[0]),
        .tmo     (r_q.tmo),
        .ref_wr  (bus_we && (bus_addr == OFS_REF)),
        .ref_data(bus_wdata),
        .cnt     (cnt_val),
        .expire  (expire)
    );

    always_comb begin
        r_d     = r_q;
        r_d.req = fault || expire;
        if (open && bus_we) begin
            if (bus_addr == OFS_CTRL) r_d.ctrl = bus_wdata;
            if (bus_addr == OFS_TMO)  r_d.tmo  = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ctrl: DATA_W'(1), tmo: TMO_RESET, req: 1'b0};
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = r_q.ctrl;
            OFS_TMO:  bus_rdata = r_q.tmo;
            OFS_CNT:  bus_rdata = cnt_val;
            OFS_KEY:  bus_rdata = {{(DATA_W-1){1'b0}}, open};
            default:  bus_rdata = '0;
        endcase
    end

    assign ctrl_q   = r_q.ctrl;
    assign tmo_q    = r_q.tmo;
    assign rst_req  = r_q.req;
    assign unlocked = open;
    assign win_left = win;
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk
    import wdog_guard_pkg::*;
#(
    parameter int WIN_CYCLES = 256,
    localparam int WIN_W = $clog2(WIN_CYCLES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              unlocked,
    input logic [WIN_W-1:0]  win_left,
    input logic              rst_req,
    input logic [DATA_W-1:0] ctrl,
    input logic [DATA_W-1:0] tmo,
    input logic [DATA_W-1:0] cnt
);
    p_open_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> win_left == WIN_W'(WIN_CYCLES));

    p_win_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked && (win_left > WIN_W'(1)) |=> unlocked && (win_left == $past(win_left) - 1'b1));

    p_win_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked == (win_left != '0));

    p_locked_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(ctrl) && $stable(tmo));

    p_timeout_fires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[0] && (cnt >= tmo) |=> rst_req);

    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |=> cnt == '0);
endmodule

bind wdog_guard wdog_guard_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .unlocked(unlocked),
    .win_left(win_left),
    .rst_req (rst_req),
    .ctrl    (ctrl_q),
    .tmo     (tmo_q),
    .cnt     (cnt_val)
);

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req, unlocked;
    logic [8:0]  win_left;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_guard u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req),
        .unlocked(unlocked), .win_left(win_left)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic refresh();
        wr(4'h4, 16'h5A5A); wr(4'h4, 16'hA5A5);
    endtask

    task automatic do_unlock();
        wr(4'hE, 16'hC520); wr(4'hE, 16'hD928);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(4'h0, v); chk("R1 ctrl", v, 16'h0001);
        rd(4'h2, v); chk("R1 timeout", v, 16'h03E8);
        rd(4'hE, v); chk("R1 locked", v, 16'h0000);
        chk("R1 win_left", 16'(win_left), 16'h0);
        chk("R1 rst_req", 16'(rst_req), 16'h0);
        rd(4'h8, v); chk("R7 unmapped", v, 16'h0000);
    endtask

    task automatic t_locked_write();
        logic [15:0] v;
        refresh();
        wr(4'h0, 16'h0000); rd(4'h0, v); chk("R6 ctrl ignored", v, 16'h0001);
        wr(4'h2, 16'h0007); rd(4'h2, v); chk("R6 timeout ignored", v, 16'h03E8);
        chk("R6 no request", 16'(rst_req), 16'h0);
    endtask

    task automatic t_unlock_ok();
        logic [15:0] v;
        refresh(); idle(10);
        do_unlock();
        chk("R2 unlocked", 16'(unlocked), 16'h1);
        chk("R2 win_left", 16'(win_left), 16'd256);
        rd(4'hE, v); chk("R7 lock bit", v, 16'h0001);
        rd(4'h6, v); chk("R9 unlock keeps count", v, 16'd12);
        idle(255); chk("R5 last window cycle", 16'(win_left), 16'd1);
        idle(1);  chk("R5 relocked", 16'(unlocked), 16'h0);
        chk("R5 win zero", 16'(win_left), 16'h0);
    endtask

    task automatic t_gap();
        refresh();
        wr(4'hE, 16'hC520); idle(19); wr(4'hE, 16'hD928);
        chk("R3 key on 20th edge", 16'(unlocked), 16'h1);
        chk("R3 no request", 16'(rst_req), 16'h0);
        idle(256);
        refresh();
        wr(4'hE, 16'hC520); idle(19);
        chk("R3 still waiting", 16'(rst_req), 16'h0);
        idle(1);
        chk("R3 late request", 16'(rst_req), 16'h1);
        chk("R3 stays locked", 16'(unlocked), 16'h0);
        idle(1);
        chk("R3 one cycle", 16'(rst_req), 16'h0);
    endtask

    task automatic t_bad_keys();
        refresh();
        wr(4'hE, 16'h1234);
        chk("R4 bad first key", 16'(rst_req), 16'h1);
        idle(1); chk("R4 pulse ends", 16'(rst_req), 16'h0);
        wr(4'hE, 16'hC520); wr(4'hE, 16'hC520);
        chk("R4 bad second key", 16'(rst_req), 16'h1);
        chk("R4 locked", 16'(unlocked), 16'h0);
    endtask

    task automatic t_window_edge();
        logic [15:0] v;
        refresh(); do_unlock(); idle(255);
        wr(4'h0, 16'h8001);
        rd(4'h0, v); chk("R5 last edge accepted", v, 16'h8001);
        refresh(); do_unlock(); idle(256);
        wr(4'h0, 16'h0001);
        rd(4'h0, v); chk("R5 write after window ignored", v, 16'h8001);
    endtask

    task automatic t_timeout();
        logic [15:0] v;
        refresh(); do_unlock(); wr(4'h2, 16'd50);
        rd(4'h2, v); chk("R7 timeout readback", v, 16'd50);
        refresh(); idle(50);
        chk("R8 before timeout", 16'(rst_req), 16'h0);
        idle(1);
        chk("R8 timeout request", 16'(rst_req), 16'h1);
        rd(4'h6, v); chk("R8 count restarted", v, 16'h0);
        idle(1);
        chk("R8 one cycle", 16'(rst_req), 16'h0);
        idle(50);
        chk("R8 period T+1", 16'(rst_req), 16'h1);
    endtask

    task automatic t_refresh_bad();
        logic [15:0] v;
        refresh(); idle(5);
        wr(4'h4, 16'h5A5A); wr(4'h4, 16'h1234);
        rd(4'h6, v); chk("R9 broken sequence", v, 16'd7);
        wr(4'h4, 16'hA5A5);
        rd(4'h6, v); chk("R9 lone second word", v, 16'd8);
    endtask

    task automatic t_disable();
        logic [15:0] v;
        int seen = 0;
        refresh(); do_unlock(); wr(4'h0, 16'h0000);
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); @(negedge clk);
            if (rst_req) seen++;
        end
        chk("R10 no timeout when off", 16'(seen), 16'h0);
        rd(4'h6, v); chk("R10 count held", v, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked_write();
        t_unlock_ok();
        t_gap();
        t_bad_keys();
        t_window_edge();
        t_timeout();
        t_refresh_bad();
        t_disable();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule